// File: doc/BRIEF.md
# Flat Single-Level Address Translator

This block maps an 8-bit virtual address onto a 12-bit physical address through one flat table of sixteen entries held in registers. The top four address bits, the virtual page number, select an entry directly. Each page is 16 bytes, so the low four bits are the offset within the page and are passed through unchanged. Each entry carries a valid flag and an 8-bit frame number, which is why the physical space is larger than the virtual one.

Software fills the table through a write port that takes an index, a frame number and a valid flag. A lookup is started by pulsing a request strobe with a virtual address. One cycle later the block returns either the physical address or a fault, when the addressed page has no mapping. After reset the table is empty, so every page faults, including page zero. A null pointer faults for as long as software leaves page zero unmapped.

Top module: `flat_mmu`

## Requirements
- R1: After reset every table entry is unmapped, so a lookup of any of the 16 pages returns a fault. While reset is asserted, `rsp_valid_o`, `fault_o` and `pa_o` are 0.
- R2: `rsp_valid_o` is 1 in exactly the cycle after a cycle in which `req_i` was sampled 1, and 0 in every other cycle.
- R3: A lookup of a mapped page returns `fault_o`=0 and `pa_o[11:4]` equal to the frame number stored for page `va_i[7:4]`.
- R4: A lookup of an unmapped page returns `fault_o`=1 with `pa_o`=0.
- R5: A write with `wr_valid_i`=0 unmaps the entry, so later lookups of that page fault.
- R6: When a write and a lookup address the same page in the same cycle, the lookup returns the entry as it stood before the write. The next lookup sees the new entry.
- R7: A write changes only the entry selected by `wr_idx_i`. Mappings of all other pages are kept.
- R8: While `rsp_valid_o` is 0, `fault_o` and `pa_o` are 0.
- R9: On a mapped lookup, `pa_o[3:0]` equals `va_i[3:0]` of the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Table write strobe |
| wr_idx_i | input | 4 | Virtual page number to write |
| wr_pfn_i | input | 8 | Frame number to store |
| wr_valid_i | input | 1 | 1 maps the page, 0 unmaps it |
| req_i | input | 1 | Lookup request strobe |
| va_i | input | 8 | Virtual address to translate |
| rsp_valid_o | output | 1 | Lookup result present this cycle |
| pa_o | output | 12 | Physical address, 0 on fault |
| fault_o | output | 1 | Page has no mapping |

## Verification
The table write and the lookup can act in the same clock cycle. They collide when both address the same page. The bench provokes this by driving a write and a request for one index in a single cycle, both when remapping a mapped page and when mapping a page that was unmapped. The scoreboard predicts the result from its model's contents before that cycle's write is applied. A follow-up lookup of the same page must then show the new mapping.

// File: rtl/mmu_pkg.sv
package mmu_pkg;
  parameter int unsigned VA_W  = 8;
  parameter int unsigned PA_W  = 12;
  parameter int unsigned OFF_W = 4;

  localparam int unsigned VPN_W   = VA_W - OFF_W;
  localparam int unsigned PFN_W   = PA_W - OFF_W;
  localparam int unsigned N_PAGES = 1 << VPN_W;

  typedef struct packed {
    logic             valid;
    logic [PFN_W-1:0] pfn;
  } pte_t;
endpackage

// File: rtl/xlat_table.sv
module xlat_table
  import mmu_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [VPN_W-1:0] wr_idx_i,
  input  pte_t             wr_pte_i,
  input  logic [VPN_W-1:0] rd_idx_i,
  output pte_t             rd_pte_o
);

  pte_t ent_q [N_PAGES];

  for (genvar g = 0; g < N_PAGES; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                      ent_q[g] <= '0;
      else if (wr_en_i && wr_idx_i == VPN_W'(g))        ent_q[g] <= wr_pte_i;
    end

    assert_other_entry_kept_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!wr_en_i || wr_idx_i != VPN_W'(g)) |=> $stable(ent_q[g]));
  end

  // read is combinational; caller samples it at the request edge (old value)
  assign rd_pte_o = ent_q[rd_idx_i];

endmodule

// File: rtl/xlat_req_stage.sv
module xlat_req_stage
  import mmu_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [OFF_W-1:0] off_i,
  input  pte_t             pte_i,
  output logic             req_q_o,
  output logic [OFF_W-1:0] off_q_o,
  output pte_t             pte_q_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q_o <= 1'b0;
      off_q_o <= '0;
      pte_q_o <= '0;
    end else begin
      req_q_o <= req_i;
      if (req_i) begin
        off_q_o <= off_i;
        pte_q_o <= pte_i;
      end
    end
  end

endmodule

// File: rtl/flat_mmu.sv
module flat_mmu
  import mmu_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [VPN_W-1:0] wr_idx_i,
  input  logic [PFN_W-1:0] wr_pfn_i,
  input  logic             wr_valid_i,
  input  logic             req_i,
  input  logic [VA_W-1:0]  va_i,
  output logic             rsp_valid_o,
  output logic [PA_W-1:0]  pa_o,
  output logic             fault_o
);

  pte_t             wr_pte, rd_pte, pte_q;
  logic             req_q;
  logic [OFF_W-1:0] off_q;

  assign wr_pte = '{valid: wr_valid_i, pfn: wr_pfn_i};

  xlat_table u_table (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_idx_i (wr_idx_i),
    .wr_pte_i (wr_pte),
    .rd_idx_i (va_i[VA_W-1:OFF_W]),
    .rd_pte_o (rd_pte)
  );

  xlat_req_stage u_stage (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_i),
    .off_i   (va_i[OFF_W-1:0]),
    .pte_i   (rd_pte),
    .req_q_o (req_q),
    .off_q_o (off_q),
    .pte_q_o (pte_q)
  );

  assign rsp_valid_o = req_q;
  assign fault_o     = req_q && !pte_q.valid;
  assign pa_o        = (req_q && pte_q.valid) ? {pte_q.pfn, off_q} : '0;

  assert_rsp_follows_req_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> rsp_valid_o);
  assert_no_spurious_rsp_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !rsp_valid_o);
  assert_idle_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_valid_o |-> (!fault_o && pa_o == '0));
  assert_fault_zero_pa_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> pa_o == '0);
  assert_offset_pass_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> (fault_o || pa_o[OFF_W-1:0] == $past(va_i[OFF_W-1:0])));

endmodule

// File: tb/tb_flat_mmu.sv
`timescale 1ns/1ps
module tb_flat_mmu;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [3:0]  wr_idx_i = '0;
  logic [7:0]  wr_pfn_i = '0;
  logic        wr_valid_i = 1'b0;
  logic        req_i = 1'b0;
  logic [7:0]  va_i = '0;
  logic        rsp_valid_o;
  logic [11:0] pa_o;
  logic        fault_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk_i = ~clk_i;

  flat_mmu dut (.*);

  typedef struct {
    bit          f;
    logic [11:0] pa;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  bit          m_v [16];
  logic [7:0]  m_p [16];

  task automatic cyc(input bit we, input int idx, input int pfn, input bit wv,
                     input bit rq, input int va, input string tag);
    logic [3:0] vpn;
    exp_t e;
    @(negedge clk_i);
    wr_en_i = we; wr_idx_i = idx[3:0]; wr_pfn_i = pfn[7:0]; wr_valid_i = wv;
    req_i = rq; va_i = va[7:0];
    if (rq) begin
      vpn   = va[7:4];
      e.f   = !m_v[vpn];
      e.pa  = m_v[vpn] ? {m_p[vpn], va[3:0]} : 12'h0;
      e.tag = tag;
      sb.push_back(e);
    end
    if (we) begin
      m_v[idx[3:0]] = wv;
      m_p[idx[3:0]] = pfn[7:0];
    end
  endtask

  task automatic wr(input int idx, input int pfn, input bit wv);
    cyc(1, idx, pfn, wv, 0, 0, "");
  endtask

  task automatic rd(input int va, input string tag);
    cyc(0, 0, 0, 0, 1, va, tag);
  endtask

  task automatic idle();
    cyc(0, 0, 0, 0, 0, 0, "");
  endtask

  // monitor: sample 1 ns after each rising edge
  always @(posedge clk_i) begin
    #1;
    if (rst_ni && !done) begin
      exp_t e;
      checks++;
      if (rsp_valid_o) begin
        if (sb.size() == 0) begin
          fails++;
          $display("FAIL R2: response with no request, got rsp_valid=1 expected 0");
        end else begin
          e = sb.pop_front();
          if (fault_o !== e.f || pa_o !== e.pa) begin
            fails++;
            $display("FAIL %s: got fault=%0b pa=%h expected fault=%0b pa=%h",
                     e.tag, fault_o, pa_o, e.f, e.pa);
          end
        end
      end else if (sb.size() != 0) begin
        e = sb.pop_front();
        fails++;
        $display("FAIL R2: missing response for %s, got rsp_valid=0 expected 1", e.tag);
      end else if (fault_o !== 1'b0 || pa_o !== 12'h0) begin
        fails++;
        $display("FAIL R8: idle outputs got fault=%0b pa=%h expected 0 000", fault_o, pa_o);
      end
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) begin m_v[i] = 0; m_p[i] = '0; end
    #1;
    checks++;
    if (rsp_valid_o !== 1'b0 || fault_o !== 1'b0 || pa_o !== 12'h0) begin
      fails++;
      $display("FAIL R1: reset outputs got %0b %0b %h expected 0 0 000",
               rsp_valid_o, fault_o, pa_o);
    end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1: empty table, every page faults
    for (int p = 0; p < 16; p++) rd((p << 4) | (15 - p), "R1");
    idle();

    // R3: mappings, including frame 0x00 and 0xFF
    wr(1, 8'h3A, 1);
    wr(7, 8'hC5, 1);
    wr(15, 8'hFF, 1);
    wr(3, 8'h00, 1);
    rd(8'h1E, "R3");
    rd(8'h7D, "R3");
    idle();
    rd(8'hF0, "R3");
    rd(8'h3F, "R3");

    // R9: offset sweep on a mapped page, back-to-back
    for (int o = 0; o < 16; o++) rd(8'h70 | o, "R9");

    // R4: unmapped pages, including null
    rd(8'h00, "R4");
    rd(8'h52, "R4");
    idle();

    // R5: unmap page 7
    wr(7, 8'hC5, 0);
    rd(8'h7D, "R5");
    rd(8'h1E, "R5");

    // R6: write and lookup of the same page in one cycle
    cyc(1, 1, 8'h44, 1, 1, 8'h1E, "R6");
    rd(8'h1E, "R6");
    cyc(1, 9, 8'h90, 1, 1, 8'h95, "R6");
    rd(8'h95, "R6");
    cyc(1, 15, 8'h12, 0, 1, 8'hF3, "R6");
    rd(8'hF3, "R6");

    // R7: writes elsewhere leave other pages intact
    wr(15, 8'hEE, 1);
    for (int i = 4; i < 15; i++) if (i != 9) wr(i, i * 3, (i % 2));
    rd(8'hF1, "R7");
    rd(8'h3C, "R7");
    rd(8'h11, "R7");
    rd(8'h9A, "R7");
    rd(8'h82, "R7");
    rd(8'h57, "R7");

    // R2: alternating request gaps
    rd(8'hF4, "R2");
    idle();
    idle();
    rd(8'h1F, "R2");
    idle();
    repeat (3) idle();

    done = 1;
    checks++;
    if (sb.size() != 0) begin
      fails++;
      $display("FAIL R2: %0d responses outstanding, expected 0", sb.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    done = 1;
    checks++;
    fails++;
    $display("FAIL watchdog: run not finished, got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule